// File: doc/BRIEF.md
# Oversampled ADC conversion sequencer

This block is the digital sequencer for an incremental oversampling converter. A start pulse begins a conversion. The block then counts sampling periods, one for every cycle in which the sampling-clock enable is high. A conversion is made of a number of elementary conversions, each lasting the oversampling ratio plus one period, followed by one closing period. When the count is complete, the block captures the raw accumulator value from its input port and raises a one-clock done pulse. The captured value is converted into a 16-bit two's-complement result.

The oversampling ratio and the number of elementary conversions are each chosen by a small power-of-two code. Both codes are captured when a conversion begins. The result is first clamped to the 16-bit signed limits. The bits below the requested effective resolution are then cleared to zero. In continuous mode, a new conversion begins right after each done pulse, so the block produces one result per conversion length. In single mode, the block returns to idle after the done pulse.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, `busy` is 0, `doneStb` is 0 and `resultOut` is 0x0000.
- R2: The conversion length is decoded as OSR = 8·2^`osrSel` and NELC = 2^`nelcSel`. `doneStb` rises after exactly NELC·(OSR+1)+1 sampling enables, counted from the clock after the start is accepted. Examples: code 0/0 gives 10 enables, 5/1 gives 515, and 7/3 gives 8201.
- R3: The period count advances only on clocks where `sampleEn` is 1. Clocks without the enable neither advance the count nor end a conversion.
- R4: `osrSel`, `nelcSel` and `resBits` are captured when a conversion starts. Changing them during a conversion has no effect on the conversion in progress.
- R5: `doneStb` is high for exactly one clock. `resultOut` changes only on the clock in which `doneStb` rises, and holds its value otherwise.
- R6: When the raw accumulator value is greater than 32767, the result before masking is 0x7FFF.
- R7: When the raw accumulator value is less than -32768, the result before masking is 0x8000.
- R8: With an effective resolution of r, the low 16-r bits of `resultOut` are 0. The upper r bits carry the clamped value.
- R9: A `resBits` value below 6 is treated as 6, and a value above 16 is treated as 16.
- R10: If `contMode` is 1 on the clock that ends a conversion, the next conversion starts at once. It uses the settings present on that clock, and `busy` stays 1.
- R11: In single mode, `busy` falls on the done clock. A `startReq` that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Sampling-period enable, one clock per period |
| startReq | input | 1 | Start a conversion; accepted only while idle |
| contMode | input | 1 | 1 = restart automatically after each result |
| osrSel | input | 3 | Oversampling-ratio code, OSR = 8·2^code |
| nelcSel | input | 2 | Elementary-conversion code, NELC = 2^code |
| resBits | input | 5 | Effective resolution in bits, clamped to 6..16 |
| rawAcc | input | 24 | Signed raw accumulator value, sampled at the end of a conversion |
| busy | output | 1 | A conversion is in progress |
| doneStb | output | 1 | One-clock pulse when a new result is ready |
| resultOut | output | 16 | Clamped and masked two's-complement result |

## Verification
The smallest and largest length codes are each run once, together with a mid-range code, to confirm that both decodes combine correctly. The sampling enable is applied at rates of one in one, one in two and one in three clocks, so that an enable-counted length can be told apart from a clock-counted one. Raw values are chosen to reach each saturation rail, to stay in range with low bits set, and to fall at resolution settings outside 6..16, which separates clamping from masking. Mid-conversion changes to the settings, a repeated start pulse and a continuous run with the settings changed between results show which inputs are captured, and at which moment.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  // Strobes from the sequencing control to the result datapath
  typedef struct packed {
    logic load;     // a conversion begins: capture settings
    logic capture;  // the final period is counted: take the result
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_len_decode.sv
module adc_seq_len_decode #(
  parameter int OSR_W = 3,
  parameter int NELC_W = 2,
  parameter int OSR_BASE_LOG2 = 3,
  parameter int CNT_W = 14
) (
  input  logic [OSR_W-1:0]  osrCode,
  input  logic [NELC_W-1:0] nelcCode,
  output logic [CNT_W-1:0]  lastIdx
);
  logic [CNT_W-1:0] osrPlusOne;

  // OSR + 1 sampling periods for each elementary conversion
  assign osrPlusOne = (CNT_W'(1) << (int'(osrCode) + OSR_BASE_LOG2)) + CNT_W'(1);
  // length - 1 = NELC * (OSR + 1): the index of the last counted period
  assign lastIdx = osrPlusOne << nelcCode;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int OSR_W = 3,
  parameter int NELC_W = 2,
  parameter int OSR_BASE_LOG2 = 3,
  parameter int CNT_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              startReq,
  input  logic              contMode,
  input  logic [OSR_W-1:0]  osrSel,
  input  logic [NELC_W-1:0] nelcSel,
  output seqStrobe_t        seqStb,
  output logic              busy
);
  logic [OSR_W-1:0]  osrQ;
  logic [NELC_W-1:0] nelcQ;
  logic [CNT_W-1:0]  periodCnt;
  logic [CNT_W-1:0]  lastIdx;
  logic              running;

  adc_seq_len_decode #(
    .OSR_W(OSR_W),
    .NELC_W(NELC_W),
    .OSR_BASE_LOG2(OSR_BASE_LOG2),
    .CNT_W(CNT_W)
  ) u_len (
    .osrCode(osrQ),
    .nelcCode(nelcQ),
    .lastIdx(lastIdx)
  );

  always_comb begin
    seqStb.capture = running && sampleEn && (periodCnt == lastIdx);
    seqStb.load    = (!running && startReq) || (seqStb.capture && contMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      periodCnt <= '0;
      osrQ      <= '0;
      nelcQ     <= '0;
    end else if (seqStb.load) begin
      running   <= 1'b1;
      periodCnt <= '0;
      osrQ      <= osrSel;
      nelcQ     <= nelcSel;
    end else if (seqStb.capture) begin
      running   <= 1'b0;
    end else if (running && sampleEn) begin
      periodCnt <= periodCnt + CNT_W'(1);
    end
  end

  assign busy = running;
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16,
  parameter int RES_W = 5,
  parameter int RES_MIN = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  seqStrobe_t              seqStb,
  input  logic [RES_W-1:0]        resBits,
  input  logic signed [ACC_W-1:0] rawAcc,
  output logic                    doneStb,
  output logic [OUT_W-1:0]        resultOut
);
  logic [RES_W-1:0] resClamped;
  logic [RES_W-1:0] resQ;
  logic [OUT_W-1:0] satVal;
  logic [OUT_W-1:0] keepMask;
  int               dropCnt;

  always_comb begin
    if (resBits < RES_W'(RES_MIN))    resClamped = RES_W'(RES_MIN);
    else if (resBits > RES_W'(OUT_W)) resClamped = RES_W'(OUT_W);
    else                              resClamped = resBits;
  end

  generate
    if (ACC_W > OUT_W) begin : g_sat
      localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
      localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;
      always_comb begin
        if (rawAcc > POS_LIM)      satVal = {1'b0, {(OUT_W-1){1'b1}}};
        else if (rawAcc < NEG_LIM) satVal = {1'b1, {(OUT_W-1){1'b0}}};
        else                       satVal = rawAcc[OUT_W-1:0];
      end
    end else begin : g_ext
      assign satVal = OUT_W'(rawAcc);
    end
  endgenerate

  always_comb begin
    dropCnt = OUT_W - int'(resQ);
    for (int i = 0; i < OUT_W; i++) keepMask[i] = (i >= dropCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ      <= RES_W'(OUT_W);
      doneStb   <= 1'b0;
      resultOut <= '0;
    end else begin
      doneStb <= seqStb.capture;
      if (seqStb.load)    resQ      <= resClamped;
      if (seqStb.capture) resultOut <= satVal & keepMask;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16,
  parameter int OSR_W = 3,
  parameter int NELC_W = 2,
  parameter int RES_W = 5,
  parameter int RES_MIN = 6,
  parameter int OSR_BASE_LOG2 = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleEn,
  input  logic                    startReq,
  input  logic                    contMode,
  input  logic [OSR_W-1:0]        osrSel,
  input  logic [NELC_W-1:0]       nelcSel,
  input  logic [RES_W-1:0]        resBits,
  input  logic signed [ACC_W-1:0] rawAcc,
  output logic                    busy,
  output logic                    doneStb,
  output logic [OUT_W-1:0]        resultOut
);
  // (2^a + 1) * 2^b + 1 fits in a + b + 1 bits
  localparam int CNT_W = OSR_BASE_LOG2 + (2 ** OSR_W) - 1 + (2 ** NELC_W) - 1 + 1;

  seqStrobe_t seqStb;
  logic       captureStb;

  adc_seq_ctrl #(
    .OSR_W(OSR_W),
    .NELC_W(NELC_W),
    .OSR_BASE_LOG2(OSR_BASE_LOG2),
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sampleEn(sampleEn),
    .startReq(startReq),
    .contMode(contMode),
    .osrSel(osrSel),
    .nelcSel(nelcSel),
    .seqStb(seqStb),
    .busy(busy)
  );

  adc_seq_datapath #(
    .ACC_W(ACC_W),
    .OUT_W(OUT_W),
    .RES_W(RES_W),
    .RES_MIN(RES_MIN)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .seqStb(seqStb),
    .resBits(resBits),
    .rawAcc(rawAcc),
    .doneStb(doneStb),
    .resultOut(resultOut)
  );

  assign captureStb = seqStb.capture;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int ACC_W = 24,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    sampleEn,
  input logic                    contMode,
  input logic                    busy,
  input logic                    doneStb,
  input logic [OUT_W-1:0]        resultOut,
  input logic                    captureStb,
  input logic signed [ACC_W-1:0] rawAcc
);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  // R3: a result can only follow a clock that carried a sampling enable
  p_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> !doneStb);

  // R5: the done pulse is one clock wide
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  // R5: the result holds except on the done clock
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !doneStb |-> $stable(resultOut));

  // R6: positive overflow lands on the positive rail
  p_sat_pos_r6: assert property (@(posedge clk) disable iff (!rstN)
    (captureStb && (rawAcc > POS_LIM)) |=> (resultOut[OUT_W-1:OUT_W-2] == 2'b01));

  // R7: negative overflow lands on the negative rail
  p_sat_neg_r7: assert property (@(posedge clk) disable iff (!rstN)
    (captureStb && (rawAcc < NEG_LIM)) |=> (resultOut == {1'b1, {(OUT_W-1){1'b0}}}));

  // R10 and R11: after a result, busy follows the mode flag from that clock
  p_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (busy == $past(contMode)));
endmodule

bind adc_conv_seq adc_conv_seq_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sampleEn(sampleEn),
  .contMode(contMode),
  .busy(busy),
  .doneStb(doneStb),
  .resultOut(resultOut),
  .captureStb(captureStb),
  .rawAcc(rawAcc)
);

// File: tb/adc_conv_seq_test.sv
module adc_conv_seq_test;
  typedef struct {
    int          len;
    logic [15:0] res;
    logic        busyAfter;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0;
  logic startReq = 1'b0;
  logic contMode = 1'b0;
  logic [2:0] osrSel = '0;
  logic [1:0] nelcSel = '0;
  logic [4:0] resBits = 5'd16;
  logic signed [23:0] rawAcc = '0;
  logic busy;
  logic doneStb;
  logic [15:0] resultOut;

  int vecCnt = 0;
  int errCnt = 0;
  int doneCount = 0;
  int enDiv = 3;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  adc_conv_seq uut (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .startReq(startReq),
    .contMode(contMode), .osrSel(osrSel), .nelcSel(nelcSel), .resBits(resBits),
    .rawAcc(rawAcc), .busy(busy), .doneStb(doneStb), .resultOut(resultOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expLen(int o, int n);
    return ((8 << o) + 1) * (1 << n) + 1;
  endfunction

  function automatic logic [15:0] expRes(int raw, int res);
    int s = (raw > 32767) ? 32767 : (raw < -32768) ? -32768 : raw;
    int r = (res < 6) ? 6 : (res > 16) ? 16 : res;
    logic [15:0] v = s[15:0];
    return v & (16'hFFFF << (16 - r));
  endfunction

  // Sampling enable: one clock in every enDiv
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase++;
      sampleEn = (phase % enDiv) == 0;
    end
  end

  // Monitor: counts enables per conversion and compares each result
  initial begin
    int enCnt = 0;
    logic prevBusy = 1'b0;
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (rstN) begin
        if (!prevBusy && startReq) enCnt = 0;
        else if (prevBusy && sampleEn) enCnt++;
        if (doneStb) begin
          if (expQ.size() == 0) begin
            check(1'b0, "R5 unexpected done", 1, 0);
          end else begin
            it = expQ.pop_front();
            check(enCnt == it.len, {it.tag, " length R2"}, enCnt, it.len);
            check(resultOut == it.res, {it.tag, " result"}, int'(resultOut), int'(it.res));
            check(busy == it.busyAfter, {it.tag, " busy after done R10/R11"}, int'(busy), int'(it.busyAfter));
          end
          enCnt = 0;
          doneCount++;
        end
        prevBusy = busy;
      end
    end
  end

  task automatic startConv(input int o, input int n, input int res, input int raw,
                           input logic cont, input logic busyAfter, input string tag);
    expItem_t it;
    @(negedge clk);
    osrSel = 3'(o); nelcSel = 2'(n); resBits = 5'(res); rawAcc = 24'(raw);
    contMode = cont; startReq = 1'b1;
    it.len = expLen(o, n); it.res = expRes(raw, res); it.busyAfter = busyAfter; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone(input int target);
    while (doneCount < target) @(posedge clk);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    repeat (2000) @(posedge clk);
    repeat (138000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", doneCount, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    expItem_t it;
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(doneStb == 1'b0, "R1 done", int'(doneStb), 0);
    check(resultOut == 16'h0, "R1 result", int'(resultOut), 0);
    rstN = 1'b1;

    // R2 shortest code, R8 at full resolution
    startConv(0, 0, 16, 1234, 1'b0, 1'b0, "R2 code0/0 R8");
    waitDone(1);
    // R2 mid code; R8 masks low 4 bits of a negative value
    startConv(5, 1, 12, -5000, 1'b0, 1'b0, "R2 code5/1 R8");
    waitDone(2);
    // R6 positive rail, enable every other clock (R3)
    enDiv = 2;
    startConv(1, 0, 16, 100000, 1'b0, 1'b0, "R6 R3");
    waitDone(3);
    // R7 negative rail with masking
    startConv(2, 2, 10, -100000, 1'b0, 1'b0, "R7");
    waitDone(4);
    // R9 low clamp (3 -> 6) and high clamp (25 -> 16)
    enDiv = 3;
    startConv(0, 0, 3, 32767, 1'b0, 1'b0, "R9 low");
    waitDone(5);
    startConv(0, 0, 25, 32767, 1'b0, 1'b0, "R9 high");
    waitDone(6);

    // R4 and R11: mid-run setting changes and a second start are ignored
    startConv(0, 1, 8, 700, 1'b0, 1'b0, "R4 R11");
    repeat (5) @(negedge clk);
    osrSel = 3'd7; nelcSel = 2'd3; resBits = 5'd16;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone(7);
    @(negedge clk);
    check(busy == 1'b0, "R11 idle after single", int'(busy), 0);
    repeat (20) @(negedge clk);
    check(doneCount == 7, "R11 no extra conversion", doneCount, 7);

    // R10 continuous: second conversion uses settings present at the first done
    startConv(0, 1, 16, 1000, 1'b1, 1'b1, "R10 first");
    @(negedge clk);
    osrSel = 3'd1; nelcSel = 2'd0; resBits = 5'd8;
    it.len = expLen(1, 0); it.res = expRes(1000, 8); it.busyAfter = 1'b0; it.tag = "R10 second";
    expQ.push_back(it);
    waitDone(8);
    @(negedge clk);
    contMode = 1'b0;
    waitDone(9);

    // R2 longest code with an enable on every clock
    enDiv = 1;
    startConv(7, 3, 16, 0, 1'b0, 1'b0, "R2 code7/3");
    waitDone(10);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all results seen", expQ.size(), 0);
    check(resultOut == 16'h0, "R5 result held", int'(resultOut), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule